// File: doc/BRIEF.md
# Echo Canceller Group Power Sequencer

This block sequences power and start-up for one group of two echo cancellers sitting on a frame-based PCM voice interface. It follows a power-up bit held in a host register. When that bit becomes set it runs an initialization pass. The pass restores every per-channel control register to its default value and zeroes the whole adaptive filter coefficient memory. It then holds the group busy until a fixed number of frame boundaries have gone by. While the group is not powered up, the receive and send sample streams skip the canceller and come out a fixed number of frames late.

A chip with several groups uses one instance per group, each with its own power-up bit. The frame strobe is a single-cycle pulse, one per frame. A sample is taken on each strobe. The register file and the coefficient RAM see plain write strobes, with an address and data. Host writes to the per-channel registers pass through this block and are dropped while it reports busy.

States: `ST_BYPASS` (powered down, paths bypassed), `ST_INIT` (sweep and frame count), `ST_ABORT` (power bit dropped during init, waiting for a frame boundary), `ST_ACTIVE` (canceller outputs selected). Transitions: BYPASS→INIT when the registered power bit is 1. INIT→ACTIVE when `INIT_FRAMES` strobes have been counted and the sweep is done. INIT→ABORT when the power bit reads 0. ABORT→BYPASS on the next frame strobe. ACTIVE→BYPASS when the power bit reads 0.

Top module: `ecpwr_group_seq`

## Requirements
- R1: While `rst_n` is low, `pcm_oe` and `mcr_pwup` are 0, `init_busy` is 0 and `rout`/`sout` are 0; `pcm_oe` is 1 from the first clock edge after reset is released.
- R2: `mcr_pwup` follows `pwup` one clock later. The cycle after `mcr_pwup` reads 1 in BYPASS, the block enters INIT and `init_busy` rises.
- R3: During INIT each register address 0 to `REG_COUNT-1` receives exactly one write with data `REG_DEFAULT`. Each coefficient address 0 to `COEF_DEPTH-1` receives exactly one write with data 0. Both sweeps start at address 0, advance by one per clock and happen only while busy.
- R4: `init_busy` falls one clock after the clock edge that captures the `INIT_FRAMES`-th (default 2) frame strobe seen in INIT.
- R5: While `init_busy` is 1, a host write request produces no write towards the register file. While it is 0, the request is forwarded combinationally with its address and data.
- R6: While bypassed, the sample on `rin`/`sin` captured at frame strobe n appears on `rout`/`sout` right after the clock edge of strobe n+`BYPASS_FRAMES` (default 2). The outputs hold between strobes. Delay stages are cleared by reset.
- R7: In ACTIVE, `rout`/`sout` equal `ec_rout`/`ec_sout` in the same cycle and `bypass_active` is 0.
- R8: If `mcr_pwup` drops to 0 during INIT, the coefficient sweep stops and `init_busy` stays 1 until the edge capturing the next frame strobe. After that edge the block is in BYPASS with `init_busy` 0.
- R9: If `mcr_pwup` drops to 0 in ACTIVE, `bypass_active` is 1 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per PCM frame |
| pwup | input | 1 | Host power-up bit for this group |
| rin | input | SAMPLE_W | Receive-side input sample |
| sin | input | SAMPLE_W | Send-side input sample |
| ec_rout | input | SAMPLE_W | Canceller receive output |
| ec_sout | input | SAMPLE_W | Canceller send output |
| host_wr_req | input | 1 | Host per-channel register write request |
| host_wr_addr | input | $clog2(REG_COUNT) | Host write address |
| host_wr_data | input | REG_W | Host write data |
| rout | output | SAMPLE_W | Receive-side output sample |
| sout | output | SAMPLE_W | Send-side output sample |
| pcm_oe | output | 1 | Output enable for the sample ports |
| mcr_pwup | output | 1 | Registered power-up bit, read back as 0 in reset |
| init_busy | output | 1 | Initialization in progress |
| bypass_active | output | 1 | Paths routed around the canceller |
| reg_wr_en | output | 1 | Register file write strobe |
| reg_wr_addr | output | $clog2(REG_COUNT) | Register file write address |
| reg_wr_data | output | REG_W | Register file write data |
| coef_we | output | 1 | Coefficient RAM write strobe |
| coef_addr | output | $clog2(COEF_DEPTH) | Coefficient RAM address |
| coef_wdata | output | COEF_W | Coefficient RAM write data |

## Verification
The assertions assume that `frame_tick` lasts one cycle and that frames are longer than the larger of `REG_COUNT` and `COEF_DEPTH` in clocks, so the sweep always finishes before the frame count does. They also assume that host write data differs from `REG_DEFAULT` whenever a host write is checked against the sweep. The bench uses a 200-clock frame, which covers the default 128-entry sweep. It changes samples only at frame strobes, uses host data of 0xC3 against a default of 0x3C, and drops the power bit well before a frame boundary so the abort path is reached in a known frame.

// File: rtl/ecpwr_pkg.sv
package ecpwr_pkg;
    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_INIT   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_ABORT  = 2'd3
    } ecpwr_state_e;
endpackage

// File: rtl/ecpwr_frame_delay.sv
// Frame-aligned delay line: capture stage plus DEPTH frame stages.
module ecpwr_frame_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NSTG = DEPTH + 1;

    logic [W-1:0] stg [NSTG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSTG; i++) stg[i] <= '0;
        end else if (tick) begin
            stg[0] <= din;
            for (int i = 1; i < NSTG; i++) stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[NSTG-1];
endmodule

// File: rtl/ecpwr_sweep.sv
// Address sweep for register defaults and coefficient clearing, one address per clock.
module ecpwr_sweep #(
    parameter int          REG_COUNT   = 64,
    parameter int          COEF_DEPTH  = 128,
    parameter int          REG_W       = 8,
    parameter int          COEF_W      = 16,
    parameter logic [7:0]  REG_DEFAULT = 8'h3C
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          run,
    output logic                          reg_we,
    output logic [$clog2(REG_COUNT)-1:0]  reg_addr,
    output logic [REG_W-1:0]              reg_data,
    output logic                          coef_we,
    output logic [$clog2(COEF_DEPTH)-1:0] coef_addr,
    output logic [COEF_W-1:0]             coef_data,
    output logic                          done
);
    localparam int RAW       = $clog2(REG_COUNT);
    localparam int CAW       = $clog2(COEF_DEPTH);
    localparam int SWEEP_LEN = (REG_COUNT > COEF_DEPTH) ? REG_COUNT : COEF_DEPTH;
    localparam int CW        = $clog2(SWEEP_LEN + 1);

    logic [CW-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         idx <= '0;
        else if (!run)                      idx <= '0;
        else if (idx != CW'(SWEEP_LEN))     idx <= idx + 1'b1;
    end

    always_comb begin
        reg_we    = run && (idx < CW'(REG_COUNT));
        reg_addr  = idx[RAW-1:0];
        reg_data  = REG_W'(REG_DEFAULT);
        coef_we   = run && (idx < CW'(COEF_DEPTH));
        coef_addr = idx[CAW-1:0];
        coef_data = '0;
        done      = (idx == CW'(SWEEP_LEN));
    end
endmodule

// File: rtl/ecpwr_seq_fsm.sv
// Power sequencing state machine with frame counter for the init window.
module ecpwr_seq_fsm
    import ecpwr_pkg::*;
#(
    parameter int INIT_FRAMES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_tick,
    input  logic pwr_req,
    input  logic sweep_done,
    output logic busy,
    output logic bypass,
    output logic sweep_run
);
    localparam int FW = $clog2(INIT_FRAMES + 1);

    ecpwr_state_e state, state_nx;
    logic [FW-1:0] fcnt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BYPASS;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   fcnt <= '0;
        else if (state != ST_INIT)                    fcnt <= '0;
        else if (frame_tick && fcnt != FW'(INIT_FRAMES)) fcnt <= fcnt + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_BYPASS: if (pwr_req) state_nx = ST_INIT;
            ST_INIT: begin
                if (!pwr_req)                                      state_nx = ST_ABORT;
                else if (fcnt == FW'(INIT_FRAMES) && sweep_done)   state_nx = ST_ACTIVE;
            end
            ST_ABORT:  if (frame_tick) state_nx = ST_BYPASS;
            ST_ACTIVE: if (!pwr_req)   state_nx = ST_BYPASS;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        bypass    = 1'b1;
        sweep_run = 1'b0;
        unique case (state)
            ST_BYPASS: ;
            ST_INIT: begin
                busy      = 1'b1;
                sweep_run = 1'b1;
            end
            ST_ABORT:  busy   = 1'b1;
            ST_ACTIVE: bypass = 1'b0;
        endcase
    end
endmodule

// File: rtl/ecpwr_group_seq.sv
module ecpwr_group_seq #(
    parameter int         SAMPLE_W      = 8,
    parameter int         REG_COUNT     = 64,
    parameter int         REG_W         = 8,
    parameter logic [7:0] REG_DEFAULT   = 8'h3C,
    parameter int         COEF_DEPTH    = 128,
    parameter int         COEF_W        = 16,
    parameter int         INIT_FRAMES   = 2,
    parameter int         BYPASS_FRAMES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          frame_tick,
    input  logic                          pwup,
    input  logic [SAMPLE_W-1:0]           rin,
    input  logic [SAMPLE_W-1:0]           sin,
    input  logic [SAMPLE_W-1:0]           ec_rout,
    input  logic [SAMPLE_W-1:0]           ec_sout,
    input  logic                          host_wr_req,
    input  logic [$clog2(REG_COUNT)-1:0]  host_wr_addr,
    input  logic [REG_W-1:0]              host_wr_data,
    output logic [SAMPLE_W-1:0]           rout,
    output logic [SAMPLE_W-1:0]           sout,
    output logic                          pcm_oe,
    output logic                          mcr_pwup,
    output logic                          init_busy,
    output logic                          bypass_active,
    output logic                          reg_wr_en,
    output logic [$clog2(REG_COUNT)-1:0]  reg_wr_addr,
    output logic [REG_W-1:0]              reg_wr_data,
    output logic                          coef_we,
    output logic [$clog2(COEF_DEPTH)-1:0] coef_addr,
    output logic [COEF_W-1:0]             coef_wdata
);
    localparam int RAW    = $clog2(REG_COUNT);
    localparam int NPATHS = 2;

    logic pwup_q, busy, bypass, sweep_run, sweep_done;
    logic sw_reg_we;
    logic [RAW-1:0]   sw_reg_addr;
    logic [REG_W-1:0] sw_reg_data;

    logic [NPATHS-1:0][SAMPLE_W-1:0] bp_in, bp_out, ec_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwup_q <= 1'b0;
            pcm_oe <= 1'b0;
        end else begin
            pwup_q <= pwup;
            pcm_oe <= 1'b1;
        end
    end

    ecpwr_seq_fsm #(.INIT_FRAMES(INIT_FRAMES)) fsm_i (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
        .pwr_req(pwup_q), .sweep_done(sweep_done),
        .busy(busy), .bypass(bypass), .sweep_run(sweep_run)
    );

    ecpwr_sweep #(
        .REG_COUNT(REG_COUNT), .COEF_DEPTH(COEF_DEPTH), .REG_W(REG_W),
        .COEF_W(COEF_W), .REG_DEFAULT(REG_DEFAULT)
    ) sweep_i (
        .clk(clk), .rst_n(rst_n), .run(sweep_run),
        .reg_we(sw_reg_we), .reg_addr(sw_reg_addr), .reg_data(sw_reg_data),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_wdata),
        .done(sweep_done)
    );

    assign bp_in[0] = rin;
    assign bp_in[1] = sin;
    assign ec_in[0] = ec_rout;
    assign ec_in[1] = ec_sout;

    for (genvar g = 0; g < NPATHS; g++) begin : g_path
        ecpwr_frame_delay #(.W(SAMPLE_W), .DEPTH(BYPASS_FRAMES)) dly_i (
            .clk(clk), .rst_n(rst_n), .tick(frame_tick),
            .din(bp_in[g]), .dout(bp_out[g])
        );
    end

    always_comb begin
        rout          = bypass ? bp_out[0] : ec_in[0];
        sout          = bypass ? bp_out[1] : ec_in[1];
        mcr_pwup      = pwup_q;
        init_busy     = busy;
        bypass_active = bypass;
        if (sw_reg_we) begin
            reg_wr_en   = 1'b1;
            reg_wr_addr = sw_reg_addr;
            reg_wr_data = sw_reg_data;
        end else begin
            reg_wr_en   = host_wr_req && !busy;
            reg_wr_addr = host_wr_addr;
            reg_wr_data = host_wr_data;
        end
    end
endmodule

// File: rtl/ecpwr_group_seq_chk.sv
module ecpwr_group_seq_chk #(
    parameter int         SAMPLE_W    = 8,
    parameter int         REG_W       = 8,
    parameter logic [7:0] REG_DEFAULT = 8'h3C
) (
    input logic                clk,
    input logic                rst_n,
    input logic                frame_tick,
    input logic                host_wr_req,
    input logic [SAMPLE_W-1:0] rout,
    input logic                pcm_oe,
    input logic                mcr_pwup,
    input logic                init_busy,
    input logic                bypass_active,
    input logic                reg_wr_en,
    input logic [REG_W-1:0]    reg_wr_data,
    input logic                coef_we
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!pcm_oe && !mcr_pwup && !init_busy));

    assert_init_needs_pwup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_busy) |-> mcr_pwup);

    assert_coef_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        coef_we |-> init_busy);

    assert_busy_blocks_host_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (init_busy && reg_wr_en) |-> (reg_wr_data == REG_W'(REG_DEFAULT)));

    assert_bypass_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass_active && $past(bypass_active) && !$past(frame_tick)) |-> $stable(rout));

    assert_run_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mcr_pwup) && !init_busy) |=> bypass_active);
endmodule

bind ecpwr_group_seq ecpwr_group_seq_chk #(
    .SAMPLE_W(SAMPLE_W), .REG_W(REG_W), .REG_DEFAULT(REG_DEFAULT)
) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .host_wr_req(host_wr_req),
    .rout(rout), .pcm_oe(pcm_oe), .mcr_pwup(mcr_pwup), .init_busy(init_busy),
    .bypass_active(bypass_active), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .coef_we(coef_we)
);

// File: tb/ecpwr_group_seq_tb.sv
`timescale 1ns/1ps
module ecpwr_group_seq_tb_top;
    localparam int FRAME_CLKS = 200;
    localparam int REG_COUNT  = 64;
    localparam int COEF_DEPTH = 128;
    localparam logic [7:0] DEF = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_tick = 1'b0;
    logic pwup = 1'b0;
    logic [7:0] rin = '0, sin = '0, ec_rout = '0, ec_sout = '0;
    logic host_wr_req = 1'b0;
    logic [5:0] host_wr_addr = '0;
    logic [7:0] host_wr_data = '0;
    logic [7:0] rout, sout, reg_wr_data;
    logic pcm_oe, mcr_pwup, init_busy, bypass_active, reg_wr_en, coef_we;
    logic [5:0] reg_wr_addr;
    logic [6:0] coef_addr;
    logic [15:0] coef_wdata;

    int tests = 0, fails = 0;
    int cnt = FRAME_CLKS - 1;
    int fr = 0;
    logic [7:0] rh [256];
    logic [7:0] sh [256];

    always #10 clk = ~clk;

    ecpwr_group_seq dut_i (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .pwup(pwup),
        .rin(rin), .sin(sin), .ec_rout(ec_rout), .ec_sout(ec_sout),
        .host_wr_req(host_wr_req), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
        .rout(rout), .sout(sout), .pcm_oe(pcm_oe), .mcr_pwup(mcr_pwup),
        .init_busy(init_busy), .bypass_active(bypass_active),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata)
    );

    // Frame driver: strobes and samples change only at negedges
    always @(negedge clk) begin
        if (!rst_n) begin
            cnt = FRAME_CLKS - 1;
            frame_tick = 1'b0;
            fr = 0;
        end else begin
            cnt = (cnt == FRAME_CLKS - 1) ? 0 : cnt + 1;
            frame_tick = (cnt == 0);
            if (frame_tick) begin
                fr = fr + 1;
                rin = 8'((fr * 37 + 5) & 255);
                sin = 8'((fr * 11 + 200) & 255);
                rh[fr & 255] = rin;
                sh[fr & 255] = sin;
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_r(input int n);
        return (n >= 3) ? rh[(n - 2) & 255] : 8'h00;
    endfunction
    function automatic logic [7:0] exp_s(input int n);
        return (n >= 3) ? sh[(n - 2) & 255] : 8'h00;
    endfunction

    // Walk to next strobe edge sample and check bypass outputs there
    task automatic check_bypass_frames(input int nframes);
        for (int k = 0; k < nframes; k++) begin
            step();
            while (cnt != 0) step();
            chk(rout == exp_r(fr), "R6 rout bypass", rout, exp_r(fr));
            chk(sout == exp_s(fr), "R6 sout bypass", sout, exp_s(fr));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        pwup = 1'b0;
        host_wr_req = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        chk(!pcm_oe && !mcr_pwup && !init_busy, "R1 reset state",
            {pcm_oe, mcr_pwup, init_busy}, 0);
        chk(rout == 0 && sout == 0, "R1 reset samples", {rout, sout}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
        chk(pcm_oe, "R1 oe after reset", pcm_oe, 1);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        int reg_seen [REG_COUNT];
        int coef_seen [COEF_DEPTH];
        int ticks, ok_cnt, bad_data, order_bad, nreg, ncoef, guard;
        bit busy_prev;

        do_reset();
        check_bypass_frames(8);

        // Power-up with full sweep
        while (cnt < 20 || cnt > 40) step();
        pwup = 1'b1;
        step();
        chk(mcr_pwup && !init_busy, "R2 mcr follows, not yet busy", {mcr_pwup, init_busy}, 2);
        step();
        chk(init_busy && !bypass_active == 0, "R2 busy rises", init_busy, 1);
        for (int i = 0; i < REG_COUNT; i++) reg_seen[i] = 0;
        for (int i = 0; i < COEF_DEPTH; i++) coef_seen[i] = 0;
        ticks = 0; bad_data = 0; order_bad = 0; nreg = 0; ncoef = 0; guard = 0;
        busy_prev = 1'b1;
        while (init_busy && guard < 5 * FRAME_CLKS) begin
            if (reg_wr_en) begin
                if (reg_wr_addr != 6'(nreg)) order_bad++;
                if (reg_wr_data != DEF) bad_data++;
                reg_seen[reg_wr_addr]++;
                nreg++;
            end
            if (coef_we) begin
                if (coef_addr != 7'(ncoef)) order_bad++;
                if (coef_wdata != 0) bad_data++;
                coef_seen[coef_addr]++;
                ncoef++;
            end
            // host write attempted mid-init, after the sweep
            host_wr_req = (nreg == REG_COUNT);
            host_wr_addr = 6'd5;
            host_wr_data = 8'hC3;
            #1;
            if (host_wr_req && !coef_we && reg_wr_en) bad_data++;
            if (cnt == 0 && guard > 0) ticks++;
            step();
            guard++;
            if (ticks == 2 && cnt != 0) begin
                chk(!init_busy, "R4 busy falls one clock after 2nd strobe", init_busy, 0);
                ticks = 99;
            end
        end
        host_wr_req = 1'b0;
        ok_cnt = 0;
        for (int i = 0; i < REG_COUNT; i++) if (reg_seen[i] == 1) ok_cnt++;
        chk(ok_cnt == REG_COUNT, "R3 each register written once", ok_cnt, REG_COUNT);
        ok_cnt = 0;
        for (int i = 0; i < COEF_DEPTH; i++) if (coef_seen[i] == 1) ok_cnt++;
        chk(ok_cnt == COEF_DEPTH, "R3 each coefficient cleared once", ok_cnt, COEF_DEPTH);
        chk(order_bad == 0, "R3 ascending sweep", order_bad, 0);
        chk(bad_data == 0, "R3 R5 sweep data and host block", bad_data, 0);
        chk(ticks == 99, "R4 init length in frames", ticks, 99);

        // Active passthrough
        for (int v = 0; v < 4; v++) begin
            ec_rout = 8'(v * 64 + 17);
            ec_sout = 8'(255 - v * 31);
            #1;
            chk(rout == ec_rout && sout == ec_sout && !bypass_active, "R7 active passthrough",
                {rout, sout}, {ec_rout, ec_sout});
            step();
        end
        host_wr_req = 1'b1; host_wr_addr = 6'd9; host_wr_data = 8'hC3;
        #1;
        chk(reg_wr_en && reg_wr_addr == 6'd9 && reg_wr_data == 8'hC3, "R5 host write forwarded",
            {reg_wr_en, reg_wr_addr, reg_wr_data}, {1'b1, 6'd9, 8'hC3});
        host_wr_req = 1'b0;

        // Leave active
        while (cnt < 20 || cnt > 150) step();
        pwup = 1'b0;
        step();
        chk(!mcr_pwup && !bypass_active, "R9 still active one cycle", bypass_active, 0);
        step();
        chk(bypass_active && rout == exp_r(fr), "R9 bypass next cycle", rout, exp_r(fr));
        check_bypass_frames(3);

        // Abort mid-init
        while (cnt < 20 || cnt > 40) step();
        pwup = 1'b1;
        repeat (10) step();
        pwup = 1'b0;
        step();
        step();
        chk(init_busy, "R8 busy held in abort", init_busy, 1);
        ok_cnt = 0; bad_data = 0;
        while (cnt != 0) begin
            if (!init_busy) ok_cnt++;
            if (coef_we) bad_data++;
            host_wr_req = 1'b1; host_wr_data = 8'hC3;
            #1;
            if (reg_wr_en) bad_data++;
            step();
        end
        host_wr_req = 1'b0;
        chk(ok_cnt == 0, "R8 busy until frame edge", ok_cnt, 0);
        chk(bad_data == 0, "R8 R5 no writes while aborting", bad_data, 0);
        chk(!init_busy && bypass_active, "R8 bypass after frame edge",
            {init_busy, bypass_active}, 1);
        chk(rout == exp_r(fr), "R8 R6 bypass data after abort", rout, exp_r(fr));
        check_bypass_frames(2);

        // Reset in the middle of operation
        pwup = 1'b1;
        repeat (5) step();
        do_reset();
        check_bypass_frames(4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule